// File: doc/BRIEF.md
# MD5 / SHA-1 message padder and word packer

This block sits in front of a 512-bit block hash engine. It takes a message one byte at a time and packs the bytes into 32-bit words. When the message ends, it appends the closing padding that MD5 and SHA-1 both need, so that the engine only ever sees whole 64-byte blocks. The padding is a terminator byte 0x80, a run of zero bytes and a 64-bit bit-length field. The two digests differ only in the byte order of the length field, and a mode input selects which one applies. The mode is captured when the end of the message is accepted.

The byte count can be preloaded with a value that is a multiple of 64. This lets a message continue after earlier passes whose full blocks were already hashed, and the preloaded value counts toward the final length field. The input side uses a valid/ready handshake. It carries an end marker that may come with the last byte or in a beat of its own, so an empty message is simply an end beat with no byte. The output side is a valid/ready word stream. Its final word is flagged.

Top module: `hash_msg_padder`

## Requirements
- R1: Bytes are packed little-endian: the first byte of each output word occupies bits 7:0, the second 15:8, the third 23:16 and the fourth 31:24.
- R2: When the message length is not a multiple of 4, the last word holds the remaining bytes in their lanes, 0x80 in the next lane, and zero in every higher lane.
- R3: When the message length is a multiple of 4, the word after the last data word is exactly 0x00000080.
- R4: Zero words follow the terminator until the two length words occupy word positions 14 and 15 of a 64-byte block. The stream length is a multiple of 16 words, and only its final word carries out_last.
- R5: When the terminator falls in word position 14 or 15 of a block, the zero fill continues through one further complete block.
- R6: The length is the total byte count times 8, as 64 bits. In MD5 mode (mode_sha = 0) the first length word is bits 31:0 and the second is bits 63:32.
- R7: In SHA-1 mode (mode_sha = 1) the length is sent big-endian: the first length word has bits 63:56 in lane 0 through bits 39:32 in lane 3, and the second has bits 31:24 in lane 0 through bits 7:0 in lane 3.
- R8: While in the data phase, load_en loads load_count (a multiple of 64) as the byte count, which then counts on. in_ready is low during a load cycle.
- R9: An end beat with no byte as the first event of a message gives exactly 16 words: 0x00000080, 13 zero words and the length.
- R10: While out_valid is high and out_ready is low, out_valid, out_word and out_last hold their values.
- R11: From the cycle after the end of a message is accepted until the final length word has been issued, in_ready is low. Offered bytes are not taken, and load_en has no effect.
- R12: After reset, and after each finished message, the block is ready with a byte count of zero. The mode used for the length field is the value present when the end beat was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sha | input | 1 | 1 = SHA-1 length order, 0 = MD5 length order |
| load_en | input | 1 | Load load_count as the byte count (data phase only) |
| load_count | input | CNT_W | Byte count to resume from, multiple of 64 |
| in_valid | input | 1 | in_byte holds a message byte |
| in_byte | input | 8 | Message byte |
| in_last | input | 1 | This beat ends the message (with or without a byte) |
| in_ready | output | 1 | Beat is accepted at this edge |
| out_valid | output | 1 | out_word holds a word |
| out_word | output | 32 | Packed message or padding word |
| out_last | output | 1 | Final word of the padded message |
| out_ready | input | 1 | Consumer takes the word at this edge |

## Verification
Two events can land in the same cycle. The first is the last data byte completing a word while the end marker is accepted: the packed word leaves and padding starts together. The second is the final length word leaving while the first byte of the next message is taken. The bench provokes the first with lengths that are multiples of 4, sending the end marker both with the last byte and as a separate beat, and it applies random back-pressure throughout. It then compares every output word against a byte-level padding model. For the second event, the bench checks that in_ready returns only once the length word has been issued, and that the next message's stream starts cleanly with a zero count.

// File: rtl/hpad_pkg.sv
// Shared types and constants of the message padder.
// Assumes 32-bit output words and 64-byte hash blocks.
package hpad_pkg;

    typedef enum logic [2:0] {
        ST_DATA = 3'd0,
        ST_TERM = 3'd1,
        ST_ZERO = 3'd2,
        ST_LEN0 = 3'd3,
        ST_LEN1 = 3'd4
    } hpad_state_e;

    localparam int HP_BLOCK_WORDS = 16;
    localparam int HP_LEN_POS     = 14;

    // Reverse the byte lanes of a 32-bit word.
    function automatic logic [31:0] hp_bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/hpad_packer.sv
// Byte-to-word assembler. It collects bytes little-endian into one word,
// signals the cycle in which a word completes, and forms the terminated
// partial word (unused lanes zero, 0x80 in the first free lane).
// Assumes take is only asserted when the completed word can be accepted.
module hpad_packer #(
    parameter int BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic [7:0]           din,
    input  logic                 clear,
    output logic                 full,
    output logic [8*BYTES-1:0]   full_word,
    output logic [8*BYTES-1:0]   term_word
);
    localparam int NB_W = $clog2(BYTES);
    localparam int W    = 8 * BYTES;

    logic [W-1:0]    acc;
    logic [NB_W-1:0] nb;

    assign full = take && (nb == NB_W'(BYTES - 1));

    // Per-lane merge of the new byte and the terminator pattern.
    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            assign full_word[8*b +: 8] = (nb == NB_W'(b)) ? din : acc[8*b +: 8];
            assign term_word[8*b +: 8] = (NB_W'(b) < nb)  ? acc[8*b +: 8] :
                                         (nb == NB_W'(b)) ? 8'h80 : 8'h00;
        end
    endgenerate

    // Accumulate bytes; empty the word on completion or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            nb  <= '0;
        end else if (clear) begin
            acc <= '0;
            nb  <= '0;
        end else if (take) begin
            if (full) begin
                acc <= '0;
                nb  <= '0;
            end else begin
                acc[8*nb +: 8] <= din;
                nb             <= nb + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hpad_counter.sv
// Message byte counter and word position within the current block.
// Assumes a loaded value is a multiple of the block size; the word
// position is taken from its word-index bits anyway.
module hpad_counter #(
    parameter int CNT_W = 61,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    input  logic             inc_byte,
    input  logic             inc_word,
    output logic [CNT_W-1:0] cnt,
    output logic [POS_W-1:0] wpos
);
    // Byte count: clear beats load beats increment.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (clear)    cnt <= '0;
        else if (load)     cnt <= load_val;
        else if (inc_byte) cnt <= cnt + 1'b1;
    end

    // Word position inside the 64-byte block, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)        wpos <= '0;
        else if (clear)    wpos <= '0;
        else if (load)     wpos <= load_val[POS_W+1:2];
        else if (inc_word) wpos <= wpos + 1'b1;
    end

endmodule

// File: rtl/hpad_ctrl.sv
// Padding sequencer. After the end of a message it walks through the
// terminator word, the zero fill and the two length words, advancing
// one step each time the output slot is free.
// Assumes wpos is the block position of the next word to be issued.
module hpad_ctrl
    import hpad_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_acc,
    input  logic             slot,
    input  logic [POS_W-1:0] wpos,
    output hpad_state_e      st,
    output logic             pad_emit,
    output logic             term_go,
    output logic             done
);
    hpad_state_e      nxt;
    logic [POS_W-1:0] wnext;
    logic             to_len;

    assign wnext  = wpos + 1'b1;
    assign to_len = (wnext == POS_W'(HP_LEN_POS));

    // Next-state selection.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_DATA: if (end_acc) nxt = ST_TERM;
            ST_TERM,
            ST_ZERO: if (slot)    nxt = to_len ? ST_LEN0 : ST_ZERO;
            ST_LEN0: if (slot)    nxt = ST_LEN1;
            ST_LEN1: if (slot)    nxt = ST_DATA;
            default:              nxt = ST_DATA;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_DATA;
        else        st <= nxt;
    end

    assign pad_emit = (st != ST_DATA) && slot;
    assign term_go  = (st == ST_TERM) && slot;
    assign done     = (st == ST_LEN1) && slot;

endmodule

// File: rtl/hpad_outreg.sv
// Single-entry output holding register for a valid/ready word stream.
// Assumes load is only asserted when the register is empty or draining.
module hpad_outreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         din_last,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_word,
    output logic         out_last
);
    // Capture a new word, or drop the current one once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_word  <= din;
            out_last  <= din_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/hash_msg_padder.sv
// MD5 / SHA-1 message padder. Packs message bytes into 32-bit words and,
// at the end of the message, appends terminator, zero fill and the 64-bit
// bit length in the byte order of the selected digest.
// Assumes load_count is a multiple of 64 and CNT_W + 3 <= 64.
module hash_msg_padder
    import hpad_pkg::*;
#(
    parameter int CNT_W = 61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sha,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_count,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [31:0]      out_word,
    output logic             out_last,
    input  logic             out_ready
);
    localparam int POS_W = $clog2(HP_BLOCK_WORDS);

    hpad_state_e      st;
    logic             slot, in_data, take, end_acc, load_ok;
    logic             full, pad_emit, term_go, done;
    logic             mode_q, ol_load, ol_last;
    logic [31:0]      full_word, term_word, ol_word;
    logic [31:0]      len_w0, len_w1;
    logic [63:0]      bits;
    logic [CNT_W-1:0] cnt;
    logic [POS_W-1:0] wpos;

    assign slot     = !out_valid || out_ready;
    assign in_data  = (st == ST_DATA);
    assign in_ready = in_data && slot && !load_en;
    assign take     = in_valid && in_ready;
    assign end_acc  = in_last && in_ready;
    assign load_ok  = load_en && in_data;

    hpad_packer #(.BYTES(4)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .din       (in_byte),
        .clear     (load_ok || term_go),
        .full      (full),
        .full_word (full_word),
        .term_word (term_word)
    );

    hpad_counter #(.CNT_W(CNT_W), .POS_W(POS_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (load_count),
        .clear    (done),
        .inc_byte (take),
        .inc_word (ol_load),
        .cnt      (cnt),
        .wpos     (wpos)
    );

    hpad_ctrl #(.POS_W(POS_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_acc  (end_acc),
        .slot     (slot),
        .wpos     (wpos),
        .st       (st),
        .pad_emit (pad_emit),
        .term_go  (term_go),
        .done     (done)
    );

    // Digest mode is frozen when the end of the message is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (end_acc) mode_q <= mode_sha;
    end

    // Bit length and its two words in the order of the chosen digest.
    always_comb begin
        bits = 64'(cnt) << 3;
        if (mode_q) begin
            len_w0 = hp_bswap32(bits[63:32]);
            len_w1 = hp_bswap32(bits[31:0]);
        end else begin
            len_w0 = bits[31:0];
            len_w1 = bits[63:32];
        end
    end

    // Select the word offered to the output register.
    always_comb begin
        unique case (st)
            ST_DATA: ol_word = full_word;
            ST_TERM: ol_word = term_word;
            ST_LEN0: ol_word = len_w0;
            ST_LEN1: ol_word = len_w1;
            default: ol_word = '0;
        endcase
    end

    assign ol_load = (in_data && full) || pad_emit;
    assign ol_last = (st == ST_LEN1);

    hpad_outreg #(.W(32)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ol_load),
        .din       (ol_word),
        .din_last  (ol_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_last  (out_last)
    );

endmodule

// File: rtl/hpad_check.sv
// Property checker for the message padder, attached by bind. It keeps
// its own byte count from the port handshakes to check the length words.
module hpad_check
    import hpad_pkg::*;
#(
    parameter int CNT_W = 61
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sha,
    input logic             load_en,
    input logic [CNT_W-1:0] load_count,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_ready,
    input logic             out_valid,
    input logic [31:0]      out_word,
    input logic             out_last,
    input logic             out_ready,
    input hpad_state_e      st
);
    logic [63:0] bc, len_q;
    logic        mode_c;
    logic [31:0] prev_word;
    logic        xfer;

    assign xfer = out_valid && out_ready;

    // Independent byte count and frozen length of the finished message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc     <= '0;
            len_q  <= '0;
            mode_c <= 1'b0;
        end else if (in_last && in_ready) begin
            len_q  <= (bc + 64'(in_valid)) << 3;
            bc     <= '0;
            mode_c <= mode_sha;
        end else if (load_en && st == ST_DATA) begin
            bc <= 64'(load_count);
        end else if (in_valid && in_ready) begin
            bc <= bc + 64'd1;
        end
    end

    // Last word handed over, to pair with the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_word <= '0;
        else if (xfer) prev_word <= out_word;
    end

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last)); // R10

    AST_NO_TAKE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        in_last && in_ready |=> !in_ready); // R11

    AST_MD5_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && out_last && !mode_c |-> prev_word == len_q[31:0] && out_word == len_q[63:32]); // R6

    AST_SHA_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && out_last && mode_c |->
            prev_word == hp_bswap32(len_q[63:32]) && out_word == hp_bswap32(len_q[31:0])); // R7

endmodule

bind hash_msg_padder hpad_check #(.CNT_W(CNT_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sha   (mode_sha),
    .load_en    (load_en),
    .load_count (load_count),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .out_last   (out_last),
    .out_ready  (out_ready),
    .st         (st)
);

// File: tb/hash_msg_padder_test.sv
`timescale 1ns/1ps
module hash_msg_padder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sha = 1'b0;
    logic        load_en = 1'b0;
    logic [60:0] load_count = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_last;
    logic        out_ready = 1'b0;

    always #10 clk = ~clk;

    hash_msg_padder #(.CNT_W(61)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sha(mode_sha), .load_en(load_en),
        .load_count(load_count), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_word(out_word), .out_last(out_last), .out_ready(out_ready)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ready_pct = 7;

    logic [7:0]  msg [0:255];
    logic [31:0] exp_w [0:63];
    int          exp_n;
    logic [31:0] got_w [0:63];
    logic        got_l [0:63];
    int          got_n = 0;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_w;
    logic        hold_l;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    // Output monitor: random back-pressure, capture transfers, hold check.
    always begin
        @(negedge clk);
        out_ready = rst_n ? (($urandom % 10) < ready_pct) : 1'b0;
        #1;
        if (rst_n) begin
            if (hold_pend) begin
                checks++;
                if (!out_valid || out_word !== hold_w || out_last !== hold_l) begin
                    errors++;
                    $display("FAIL R10 stall hold: actual v=%0b w=%08h expected v=1 w=%08h",
                             out_valid, out_word, hold_w);
                end
            end
            hold_pend = out_valid && !out_ready;
            hold_w    = out_word;
            hold_l    = out_last;
            if (out_valid && out_ready) begin
                if (got_n < 64) begin
                    got_w[got_n] = out_word;
                    got_l[got_n] = out_last;
                end
                got_n++;
            end
        end
    end

    // Byte-level reference padding, then little-endian word packing.
    task automatic build_exp(input int n, input logic [63:0] pre, input logic sha);
        logic [7:0]  b [0:319];
        logic [63:0] bits;
        int k = 0;
        for (int i = 0; i < n; i++) begin b[k] = msg[i]; k++; end
        b[k] = 8'h80; k++;
        while ((k % 64) != 56) begin b[k] = 8'h00; k++; end
        bits = (pre + 64'(n)) << 3;
        for (int j = 0; j < 8; j++) begin
            b[k] = sha ? bits[63-8*j -: 8] : bits[8*j +: 8];
            k++;
        end
        exp_n = k / 4;
        for (int w = 0; w < exp_n; w++)
            exp_w[w] = {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]};
    endtask

    function automatic string tag_of(int w, int n, logic sha, logic [63:0] pre, bit after_pre);
        if (n == 0) return "R9";
        if (w < n / 4) return "R1";
        if (w == n / 4) return (n % 4 != 0) ? "R2" : "R3";
        if (w >= exp_n - 2) begin
            if (pre != 0) return "R8";
            if (after_pre) return "R12";
            return sha ? "R7" : "R6";
        end
        return (((n / 4) % 16) >= 14) ? "R5" : "R4";
    endfunction

    task automatic run_msg(input int n, input logic sha, input logic [63:0] pre,
                           input bit after_pre, input bit sep_end);
        int beats;
        int i;
        int bad_last;
        for (int k = 0; k < n; k++) msg[k] = 8'($urandom);
        build_exp(n, pre, sha);
        got_n = 0;
        if (pre != 0) begin
            @(negedge clk);
            load_en = 1'b1;
            load_count = pre[60:0];
            #2;
            checks++;
            if (in_ready !== 1'b0) begin
                errors++;
                $display("FAIL R8 in_ready during load: actual=%0b expected=0", in_ready);
            end
            @(negedge clk);
            load_en = 1'b0;
        end
        mode_sha = sha;
        beats = (sep_end || n == 0) ? n + 1 : n;
        i = 0;
        while (i < beats) begin
            @(negedge clk);
            if (($urandom % 4) == 0) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end else begin
                in_valid = (i < n);
                in_byte  = (i < n) ? msg[i] : 8'h00;
                in_last  = (i == beats - 1);
                #2;
                if (in_ready) i++;
            end
        end
        // Padding phase: offer a junk byte, a junk load and flip the mode.
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = 8'hEE;
        in_last = 1'b0;
        mode_sha = ~sha;
        load_en = 1'b1;
        load_count = 61'd320;
        #2;
        checks++;
        if (in_ready !== 1'b0) begin
            errors++;
            $display("FAIL R11 in_ready after end: actual=%0b expected=0", in_ready);
        end
        while (1) begin
            @(negedge clk);
            load_en = 1'b0;
            #2;
            if (in_ready) begin
                in_valid = 1'b0;
                checks++;
                if (!(got_n == exp_n || (out_valid && out_last))) begin
                    errors++;
                    $display("FAIL R11 ready returned early: actual words=%0d expected=%0d",
                             got_n, exp_n);
                end
                break;
            end
        end
        while (got_n < exp_n) @(negedge clk);
        repeat (4) @(negedge clk);
        #3;
        checks++;
        if (got_n != exp_n) begin
            errors++;
            $display("FAIL R4 word count n=%0d: actual=%0d expected=%0d", n, got_n, exp_n);
        end
        for (int w = 0; w < exp_n && w < 64; w++) begin
            checks++;
            if (got_w[w] !== exp_w[w]) begin
                errors++;
                $display("FAIL %s n=%0d sha=%0b word %0d: actual=%08h expected=%08h",
                         tag_of(w, n, sha, pre, after_pre), n, sha, w, got_w[w], exp_w[w]);
            end
        end
        bad_last = 0;
        for (int w = 0; w < exp_n && w < 64; w++)
            if (got_l[w] !== (w == exp_n - 1)) bad_last++;
        checks++;
        if (bad_last != 0) begin
            errors++;
            $display("FAIL R4 out_last placement n=%0d: actual bad=%0d expected=0", n, bad_last);
        end
    endtask

    initial begin
        int lens [12] = '{0, 1, 2, 3, 4, 55, 56, 59, 60, 63, 64, 65};
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset state: actual ready=%0b valid=%0b expected ready=1 valid=0",
                     in_ready, out_valid);
        end
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 12; k++)
                run_msg(lens[k], s[0], 64'd0, 1'b0, k[0]);
        ready_pct = 3;
        run_msg(5, 1'b1, 64'd192, 1'b0, 1'b0);
        run_msg(7, 1'b1, 64'd0, 1'b1, 1'b0);
        run_msg(3, 1'b0, 64'h0000_0012_3456_7800, 1'b0, 1'b1);
        run_msg(0, 1'b0, 64'd0, 1'b1, 1'b1);
        run_msg(60, 1'b0, 64'd64, 1'b0, 1'b0);
        ready_pct = 7;
        for (int r = 0; r < 40; r++) begin
            logic [63:0] pre;
            pre = (($urandom % 4) == 0) ? 64'($urandom % 1024) * 64 : 64'd0;
            ready_pct = 3 + ($urandom % 8);
            run_msg($urandom % 140, 1'($urandom), pre, 1'b0, 1'($urandom));
        end
        summary();
        $finish;
    end

endmodule